// File: doc/BRIEF.md
# Serial Bitstream Frame Synchronizer

This block accepts a serial bit stream with its accompanying bit clock, both already brought into the system clock domain. It looks for a configurable synchronisation pattern at every bit position. Once it finds the pattern, it realigns the stream so that output byte boundaries fall a whole number of bytes after the first pattern bit. It then delivers every frame as a stream of bytes. The pattern bytes come first, flagged as start-of-frame, and the payload bytes follow.

The pattern value, its length in bytes and the frame length in bytes are run-time inputs. While locked, a frame-length bit counter predicts where the next pattern must start, and the pattern is compared there only. Occasional corrupted patterns are bridged by a flywheel. A run of consecutive misses releases the lock, and the block hunts again.

Each output byte appears after its last bit has been shifted in. With a one-byte pattern a byte appears as soon as its eighth bit arrives. With a longer pattern each byte appears (pattern bytes − 1) × 8 bits later, so that the first pattern byte can be emitted at the moment the whole pattern is recognised.

Top module: `bitframe_sync`

## Requirements
- R1: A synchronous active-high reset clears `locked`, `out_valid` and `out_sof`, and forces hunting.
- R2: With `cfg_fall_edge` = 0 a data bit is taken on each 0→1 change of `ser_clk`. With 1 it is taken on each 1→0 change. The level of `ser_dat` while the other change happens is ignored.
- R3: While not locked, the block compares the most recent `8*cfg_sync_bytes` bits with the pattern on every data bit, whatever the bit offset. No byte is output while it hunts.
- R4: When the pattern is found, `locked` rises and the first pattern byte is output with `out_sof` = 1. Each further byte holds the next 8 bits, first-received bit in bit 7.
- R5: Each locked frame yields exactly `cfg_frame_bytes` bytes. The pattern bytes come first, and `out_sof` marks the first byte of every frame whose pattern was confirmed.
- R6: While locked, the pattern is checked only where the frame counter predicts it. A single miss keeps `locked` high and bytes still flow, without `out_sof`.
- R7: `MISS_LIMIT` (default 2) consecutive misses at predicted positions clear `locked`. The byte at that point is not output, and hunting resumes on the next bit.
- R8: A hit at the predicted position after a miss restores normal tracking, and that frame's first byte carries `out_sof`.
- R9: Pattern length (1 to `SYNC_MAX_BYTES` bytes, value right-aligned in `cfg_sync_word`) and frame length (in bytes, greater than the pattern length) are taken from the configuration inputs.
- R10: `out_valid` is a single-cycle pulse in the cycle after the data bit that completes a byte. `out_sof` is only ever high together with `out_valid`.
- R11: A copy of the pattern inside the payload while locked causes no realignment and no `out_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Bit clock, synchronised to `clk` |
| ser_dat | input | 1 | Serial data, synchronised to `clk` |
| cfg_fall_edge | input | 1 | 0: take bits on rising `ser_clk`; 1: on falling |
| cfg_sync_word | input | 8*SYNC_MAX_BYTES | Pattern value, right-aligned, sent MSB first |
| cfg_sync_bytes | input | $clog2(SYNC_MAX_BYTES+1) | Pattern length in bytes |
| cfg_frame_bytes | input | $clog2(FRAME_MAX_BYTES+1) | Frame length in bytes, pattern included |
| out_valid | output | 1 | One-cycle strobe for `out_byte` |
| out_byte | output | 8 | Realigned output byte |
| out_sof | output | 1 | First byte of a confirmed frame |
| locked | output | 1 | Frame alignment held |

## Verification
The hardest situation to reach from the ports is the flywheel path. A single bad pattern must be tolerated, while a second consecutive one must drop lock exactly at its predicted position. Nothing inside the payload may trigger either event early. The stimulus builds frames by hand: it corrupts the pattern of one frame, restores the next, and then corrupts two in a row. It also embeds the pattern inside payload bytes and inserts odd numbers of filler bits before relocking, so that hunting resumes at a new bit offset. A behavioural model that works on a queue of received bits predicts every output cycle.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_LOCKED = 2'd1,
      ST_VERIFY = 2'd2
   } fs_state_t;

   // width of a byte lane
   localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/fsync_edge.sv
// Turns the synchronised bit clock into a one-cycle strobe on the chosen edge.
module fsync_edge (
   input  logic clk,
   input  logic rst,
   input  logic ser_clk,
   input  logic ser_dat,
   input  logic cfg_fall_edge,
   output logic bit_stb,
   output logic bit_val
);

   logic clk_q;

   // track the level so that reset does not manufacture an edge
   always_ff @(posedge clk) begin
      clk_q <= ser_clk;
   end

   logic rise, fall;
   assign rise    = ser_clk & ~clk_q;
   assign fall    = ~ser_clk & clk_q;
   assign bit_stb = ~rst & (cfg_fall_edge ? fall : rise);
   assign bit_val = ser_dat;

endmodule

// File: rtl/fsync_matcher.sv
// Sliding window plus per-lane pattern compare and output byte tap.
module fsync_matcher #(
   parameter int unsigned SYNC_MAX_BYTES = 4,
   localparam int unsigned SW  = SYNC_MAX_BYTES * fsync_pkg::LANE_W,
   localparam int unsigned SBW = $clog2(SYNC_MAX_BYTES + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bit_stb,
   input  logic           bit_val,
   input  logic [SW-1:0]  cfg_sync_word,
   input  logic [SBW-1:0] cfg_sync_bytes,
   output logic           hit,
   output logic [7:0]     tap_byte
);

   logic [SW-2:0] win;
   logic [SW-1:0] nwin;

   // window as it will be once the current bit is included
   assign nwin = {win, bit_val};

   always_ff @(posedge clk) begin
      if (rst) begin
         win <= '0;
      end else if (bit_stb) begin
         win <= nwin[SW-2:0];
      end
   end

   logic [SYNC_MAX_BYTES-1:0] lane_ok;
   logic [7:0]                tap_cand [SYNC_MAX_BYTES];

   for (genvar g = 0; g < SYNC_MAX_BYTES; g++) begin : g_lane
      logic lane_used;
      assign lane_used   = (SBW'(g) < cfg_sync_bytes);
      assign lane_ok[g]  = ~lane_used |
                           (nwin[g*8 +: 8] == cfg_sync_word[g*8 +: 8]);
      assign tap_cand[g] = nwin[g*8 +: 8];
   end

   assign hit = &lane_ok;

   // the oldest pattern-length lane holds the byte to emit
   always_comb begin
      tap_byte = '0;
      for (int i = 0; i < SYNC_MAX_BYTES; i++) begin
         if (SBW'(i + 1) == cfg_sync_bytes) tap_byte = tap_cand[i];
      end
   end

endmodule

// File: rtl/fsync_track.sv
// Hunt / locked / verify state machine, frame bit counter and byte output.
module fsync_track
   import fsync_pkg::*;
#(
   parameter int unsigned FRAME_MAX_BYTES = 64,
   parameter int unsigned MISS_LIMIT      = 2,
   localparam int unsigned FBW = $clog2(FRAME_MAX_BYTES + 1),
   localparam int unsigned CNW = $clog2(FRAME_MAX_BYTES * 8) + 1,
   localparam int unsigned MW  = $clog2(MISS_LIMIT + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bit_stb,
   input  logic           hit,
   input  logic [7:0]     tap_byte,
   input  logic [FBW-1:0] cfg_frame_bytes,
   output logic           out_valid,
   output logic [7:0]     out_byte,
   output logic           out_sof,
   output logic           locked
);

   fs_state_t      state;
   logic [CNW-1:0] cnt, cnt_nxt, last_bit;
   logic [MW-1:0]  miss_cnt, miss_inc;
   logic           at_byte, at_sync, give_up;

   assign last_bit = (CNW'(cfg_frame_bytes) << 3) - CNW'(1);
   assign cnt_nxt  = (cnt == last_bit) ? '0 : cnt + CNW'(1);
   assign at_byte  = (cnt_nxt[2:0] == 3'd0);
   assign at_sync  = (cnt_nxt == '0);
   assign miss_inc = miss_cnt + MW'(1);
   assign give_up  = (miss_inc >= MW'(MISS_LIMIT));

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_HUNT;
         cnt       <= '0;
         miss_cnt  <= '0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_byte  <= '0;
         locked    <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         if (bit_stb) begin
            unique case (state)
               ST_HUNT: begin
                  if (hit) begin
                     state     <= ST_LOCKED;
                     cnt       <= '0;
                     miss_cnt  <= '0;
                     locked    <= 1'b1;
                     out_valid <= 1'b1;
                     out_sof   <= 1'b1;
                     out_byte  <= tap_byte;
                  end
               end
               ST_LOCKED, ST_VERIFY: begin
                  cnt <= cnt_nxt;
                  if (at_sync && hit) begin
                     state     <= ST_LOCKED;
                     miss_cnt  <= '0;
                     out_valid <= 1'b1;
                     out_sof   <= 1'b1;
                     out_byte  <= tap_byte;
                  end else if (at_sync && give_up) begin
                     state    <= ST_HUNT;
                     miss_cnt <= '0;
                     locked   <= 1'b0;
                  end else if (at_sync) begin
                     state     <= ST_VERIFY;
                     miss_cnt  <= miss_inc;
                     out_valid <= 1'b1;
                     out_byte  <= tap_byte;
                  end else if (at_byte) begin
                     out_valid <= 1'b1;
                     out_byte  <= tap_byte;
                  end
               end
               default: state <= ST_HUNT;
            endcase
         end
      end
   end

endmodule

// File: rtl/bitframe_sync.sv
module bitframe_sync #(
   parameter int unsigned SYNC_MAX_BYTES  = 4,
   parameter int unsigned FRAME_MAX_BYTES = 64,
   parameter int unsigned MISS_LIMIT      = 2,
   localparam int unsigned SW  = SYNC_MAX_BYTES * 8,
   localparam int unsigned SBW = $clog2(SYNC_MAX_BYTES + 1),
   localparam int unsigned FBW = $clog2(FRAME_MAX_BYTES + 1)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           ser_clk,
   input  logic           ser_dat,
   input  logic           cfg_fall_edge,
   input  logic [SW-1:0]  cfg_sync_word,
   input  logic [SBW-1:0] cfg_sync_bytes,
   input  logic [FBW-1:0] cfg_frame_bytes,
   output logic           out_valid,
   output logic [7:0]     out_byte,
   output logic           out_sof,
   output logic           locked
);

   initial begin
      assert (SYNC_MAX_BYTES >= 1)
         else $fatal(1, "SYNC_MAX_BYTES must be at least 1");
      assert (FRAME_MAX_BYTES > SYNC_MAX_BYTES)
         else $fatal(1, "FRAME_MAX_BYTES must exceed SYNC_MAX_BYTES");
      assert (MISS_LIMIT >= 1)
         else $fatal(1, "MISS_LIMIT must be at least 1");
   end

   logic       bit_stb, bit_val, hit;
   logic [7:0] tap_byte;

   fsync_edge u_edge (
      .clk           (clk),
      .rst           (rst),
      .ser_clk       (ser_clk),
      .ser_dat       (ser_dat),
      .cfg_fall_edge (cfg_fall_edge),
      .bit_stb       (bit_stb),
      .bit_val       (bit_val)
   );

   fsync_matcher #(.SYNC_MAX_BYTES(SYNC_MAX_BYTES)) u_match (
      .clk            (clk),
      .rst            (rst),
      .bit_stb        (bit_stb),
      .bit_val        (bit_val),
      .cfg_sync_word  (cfg_sync_word),
      .cfg_sync_bytes (cfg_sync_bytes),
      .hit            (hit),
      .tap_byte       (tap_byte)
   );

   fsync_track #(
      .FRAME_MAX_BYTES (FRAME_MAX_BYTES),
      .MISS_LIMIT      (MISS_LIMIT)
   ) u_track (
      .clk             (clk),
      .rst             (rst),
      .bit_stb         (bit_stb),
      .hit             (hit),
      .tap_byte        (tap_byte),
      .cfg_frame_bytes (cfg_frame_bytes),
      .out_valid       (out_valid),
      .out_byte        (out_byte),
      .out_sof         (out_sof),
      .locked          (locked)
   );

endmodule

// File: rtl/fsync_chk.sv
module fsync_chk (
   input logic clk,
   input logic rst,
   input logic locked,
   input logic out_valid,
   input logic out_sof
);

   // R1
   rst_clears_chk: assert property (@(posedge clk)
      rst |=> (!locked && !out_valid && !out_sof));

   // R10
   sof_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
      out_sof |-> out_valid);

   // R10
   valid_single_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R3
   quiet_hunt_chk: assert property (@(posedge clk) disable iff (rst)
      !locked |-> !out_valid);

   // R4
   lock_sof_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> out_sof);

   // R7
   drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> (!out_valid && !out_sof));

endmodule

bind bitframe_sync fsync_chk chk_i (
   .clk       (clk),
   .rst       (rst),
   .locked    (locked),
   .out_valid (out_valid),
   .out_sof   (out_sof)
);

// File: tb/bitframe_sync_test.sv
module bitframe_sync_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        cfg_fall_edge = 1'b0;
   logic [31:0] cfg_sync_word = 32'h0000FDF2;
   logic [2:0]  cfg_sync_bytes = 3'd2;
   logic [6:0]  cfg_frame_bytes = 7'd6;
   logic        out_valid, out_sof, locked;
   logic [7:0]  out_byte;

   always #4 clk = ~clk;

   bitframe_sync uut (
      .clk (clk), .rst (rst), .ser_clk (ser_clk), .ser_dat (ser_dat),
      .cfg_fall_edge (cfg_fall_edge), .cfg_sync_word (cfg_sync_word),
      .cfg_sync_bytes (cfg_sync_bytes), .cfg_frame_bytes (cfg_frame_bytes),
      .out_valid (out_valid), .out_byte (out_byte), .out_sof (out_sof),
      .locked (locked)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   bit   q[$];
   int   m_state;      // 0 hunting, 1 tracking, 2 after a miss
   int   m_pos;
   int   m_miss;
   bit   exp_valid, exp_sof, exp_locked;
   byte  exp_byte;
   byte  got[$];
   int   sof_seen;

   function automatic bit bit_at(int j);
      if (j < 0) return 1'b0;
      return q[j];
   endfunction

   function automatic bit tail_match();
      int s = 8 * int'(cfg_sync_bytes);
      int n = q.size();
      for (int i = 0; i < s; i++)
         if (bit_at(n - s + i) != cfg_sync_word[s - 1 - i]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic byte oldest_byte();
      int s = 8 * int'(cfg_sync_bytes);
      int n = q.size();
      byte v = 0;
      for (int i = 0; i < 8; i++) v[7 - i] = bit_at(n - s + i);
      return v;
   endfunction

   task automatic model_step(input bit b);
      int fbits = 8 * int'(cfg_frame_bytes);
      q.push_back(b);
      exp_valid = 0;
      exp_sof   = 0;
      if (m_state == 0) begin
         if (tail_match()) begin
            m_state = 1; m_pos = 0; m_miss = 0; exp_locked = 1;
            exp_valid = 1; exp_sof = 1; exp_byte = oldest_byte();
         end
      end else begin
         m_pos = (m_pos + 1) % fbits;
         if (m_pos == 0) begin
            if (tail_match()) begin
               m_state = 1; m_miss = 0;
               exp_valid = 1; exp_sof = 1; exp_byte = oldest_byte();
            end else if (m_miss + 1 >= 2) begin
               m_state = 0; m_miss = 0; exp_locked = 0;
            end else begin
               m_state = 2; m_miss++;
               exp_valid = 1; exp_byte = oldest_byte();
            end
         end else if (m_pos % 8 == 0) begin
            exp_valid = 1; exp_byte = oldest_byte();
         end
      end
   endtask

   task automatic compare();
      chk(locked == exp_locked, "R7 locked", locked, exp_locked);
      chk(out_valid == exp_valid, "R10 out_valid", out_valid, exp_valid);
      chk(out_sof == exp_sof, "R5 out_sof", out_sof, exp_sof);
      if (exp_valid && out_valid)
         chk(out_byte == exp_byte, "R4 out_byte", out_byte, exp_byte);
      if (out_valid) got.push_back(out_byte);
      if (out_valid && out_sof) sof_seen++;
   endtask

   // called at a falling clk edge; returns at a falling clk edge
   task automatic send_bit(input bit b);
      ser_dat = b;
      ser_clk = cfg_fall_edge ? 1'b0 : 1'b1;
      @(negedge clk);
      model_step(b);
      compare();
      ser_clk = cfg_fall_edge ? 1'b1 : 1'b0;
      ser_dat = 1'($urandom);      // level on the ignored edge: R2
      @(negedge clk);
      exp_valid = 0; exp_sof = 0;
      compare();
   endtask

   task automatic send_byte(input byte v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic send_bits(input int v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic do_reset(input bit fall, input int word, input int sb, input int fb);
      @(negedge clk);
      rst = 1;
      cfg_fall_edge   = fall;
      cfg_sync_word   = word;
      cfg_sync_bytes  = 3'(sb);
      cfg_frame_bytes = 7'(fb);
      ser_clk = fall;
      repeat (3) @(negedge clk);
      // R1: state after reset edges
      chk(locked == 0, "R1 locked", locked, 0);
      chk(out_valid == 0, "R1 out_valid", out_valid, 0);
      chk(out_sof == 0, "R1 out_sof", out_sof, 0);
      rst = 0;
      q.delete(); got.delete();
      m_state = 0; m_pos = 0; m_miss = 0;
      exp_locked = 0; exp_valid = 0; exp_sof = 0; exp_byte = 0;
      sof_seen = 0;
   endtask

   task automatic expect_bytes(input byte e[], input string tag);
      chk(got.size() == e.size(), tag, got.size(), e.size());
      for (int i = 0; i < e.size() && i < got.size(); i++)
         chk(got[i] == e[i], tag, got[i], e[i]);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired (no requirement) actual=hung expected=done");
      finish_run();
   end

   initial begin
      byte fr[];

      // R3 R4 R5 R11: 16-bit pattern at an odd offset, pattern copy in payload
      do_reset(0, 32'hFDF2, 2, 6);
      send_bits(5'b10110, 5);
      fr = '{8'hFD,8'hF2,8'h01,8'h89,8'h03,8'h45,
             8'hFD,8'hF2,8'h90,8'h88,8'h4A,8'h12,
             8'hFD,8'hF2,8'h78,8'h15,8'h29,8'h44,
             8'hFD,8'hF2,8'hFD,8'hF2,8'h00,8'h00,
             8'hFD,8'hF2,8'h11,8'h22,8'h33,8'h44};
      foreach (fr[i]) send_byte(fr[i]);
      send_byte(8'h00);
      expect_bytes(fr, "R4 realigned stream");
      chk(sof_seen == 5, "R11 sof count", sof_seen, 5);

      // R6 R7 R8 R3: flywheel, drop and relock at a new offset
      do_reset(0, 32'hFDF2, 2, 6);
      send_bits(3'b001, 3);
      send_byte(8'hFD); send_byte(8'hF2); repeat (4) send_byte(8'h5A);
      send_byte(8'hFD); send_byte(8'hF3); repeat (4) send_byte(8'h21);
      chk(locked == 1, "R6 single miss keeps lock", locked, 1);
      send_byte(8'hFD); send_byte(8'hF2); repeat (4) send_byte(8'h33);
      send_byte(8'h0D); send_byte(8'hF2); repeat (4) send_byte(8'h00);
      send_byte(8'hFD); send_byte(8'h02); repeat (4) send_byte(8'h00);
      chk(locked == 0, "R7 two misses drop lock", locked, 0);
      chk(got.size() == 24, "R7 bytes before drop", got.size(), 24);
      send_bits(3'b010, 3);
      send_byte(8'hFD); send_byte(8'hF2); repeat (4) send_byte(8'h44);
      send_byte(8'hFD); send_byte(8'hF2); repeat (4) send_byte(8'h55);
      send_byte(8'h00);
      chk(locked == 1, "R3 relock", locked, 1);
      chk(got.size() == 36, "R8 total bytes", got.size(), 36);
      chk(sof_seen == 4, "R8 sof count", sof_seen, 4);

      // R2 R9: falling edge, 3-byte pattern, 5-byte frame
      do_reset(1, 32'h1ACFFC, 3, 5);
      send_bits(3'b110, 3);
      fr = '{8'h1A,8'hCF,8'hFC,8'h5A,8'hA5, 8'h1A,8'hCF,8'hFC,8'h01,8'h02};
      foreach (fr[i]) send_byte(fr[i]);
      send_byte(8'h00); send_byte(8'h00);
      expect_bytes(fr, "R2 falling edge stream");
      chk(sof_seen == 2, "R9 sof count", sof_seen, 2);

      // R9: one-byte pattern, 4-byte frame
      do_reset(0, 32'h47, 1, 4);
      send_bits(6'b110100, 6);
      fr = '{8'h47,8'h10,8'h20,8'h30, 8'h47,8'h40,8'h50,8'h60};
      foreach (fr[i]) send_byte(fr[i]);
      expect_bytes(fr, "R9 short pattern stream");

      finish_run();
   end

endmodule